// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor and arbitrates its load-linked (LL) and store-conditional (SC) operations. An LL reads a word from memory, returns it to the processor and records a reservation on the aligned line that holds the word. A later SC to the same line asks for the bus. It writes memory only if no other agent has written that line in the meantime. The outcome comes back to the processor as a one-cycle done pulse with a success flag.

Writes by other agents arrive on a snoop address input. A snooped write anywhere in the reserved line drops the reservation. An SC that finds no reservation fails at once and never raises a bus request. An SC that is waiting for the bus fails if a conflicting write is snooped before or in the same cycle as the grant. That snooped write can come from another processor whose SC reached the bus first. A failed SC drives no memory write. The processor's own plain stores also go through the block, and a store to the reserved line cancels the reservation.

Top module: `resv_monitor`

## Requirements
- R1: A request with `req_op` = 2'b01 (LL) accepted while `req_ready` is high drives `ll_valid` high for one cycle on the next cycle, with `ll_data` equal to the memory word at `req_addr`, and records a reservation on the line `req_addr[ADDR_W-1:LINE_W]`.
- R2: An SC (`req_op` = 2'b10) whose line matches a live reservation raises `bus_req` on the next cycle and holds it, with `req_ready` low, until the grant. In the cycle after `bus_gnt` is sampled high, `mem_we`, `sc_done` and `sc_ok` are high and `mem_waddr`/`mem_wdata` carry the SC address and data.
- R3: An SC made with no live reservation, or to a different line, fails early. On the next cycle `sc_done` is high and `sc_ok` is low, `bus_req` stays low and `mem_we` stays low.
- R4: A snooped write (`snoop_valid`) to any word of the reserved line clears the reservation. A snooped write to another line leaves it in place.
- R5: A snooped write to the reserved line while `bus_req` is high makes the SC fail, even when it coincides with `bus_gnt`. On the next cycle `sc_done` is high, `sc_ok` is low, `mem_we` is low and `bus_req` is low.
- R6: Every completed SC, whether it succeeds or fails, clears the reservation.
- R7: A new LL replaces any earlier reservation with the new line.
- R8: A plain store (`req_op` = 2'b11) drives `mem_we` with its address and data on the next cycle. It clears the reservation when it hits the reserved line and leaves it in place otherwise.
- R9: An LL accepted in the same cycle as a snooped write to its own line does not leave a reservation.
- R10: After reset `req_ready` is high, `bus_req`, `mem_we`, `sc_done`, `sc_ok` and `ll_valid` are low, and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 01 LL, 10 SC, 11 store, 00 none |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store / SC data |
| req_ready | output | 1 | Block can accept a request |
| mem_raddr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data, combinational |
| ll_valid | output | 1 | LL data valid pulse |
| ll_data | output | DATA_W | LL data |
| snoop_valid | input | 1 | Another agent wrote memory |
| snoop_addr | input | ADDR_W | Word address of the snooped write |
| bus_req | output | 1 | SC requests the bus |
| bus_gnt | input | 1 | Bus granted to this SC |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| sc_done | output | 1 | SC completed pulse |
| sc_ok | output | 1 | SC succeeded, valid with sc_done |

## Verification
The reservation cannot be seen directly, so the bench exposes it each time by following up with an SC. A stale valid bit shows up as a wrongly successful SC with a spurious `mem_we`. A lost valid bit shows up as a failed SC with no `bus_req`. Either result is visible one cycle after the SC is accepted. A line compare that is too wide or too narrow shows up as a snoop to a neighbouring word that is ignored, or as a snoop to another line that kills the reservation, both found by the next SC. A wrong race priority between snoop and grant shows up as `sc_ok` together with `mem_we` in the cycle after the coincidence.

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ll_valid,
  output logic [DATA_W-1:0] ll_data,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              sc_done,
  output logic              sc_ok
);

  localparam int TAG_W = ADDR_W - LINE_W;
  localparam logic [1:0] OP_LL = 2'b01;
  localparam logic [1:0] OP_SC = 2'b10;
  localparam logic [1:0] OP_ST = 2'b11;

  logic              waiting;
  logic              resv_valid;
  logic [TAG_W-1:0]  resv_tag;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  wire [TAG_W-1:0] req_tag   = req_addr[ADDR_W-1:LINE_W];
  wire [TAG_W-1:0] snoop_tag = snoop_addr[ADDR_W-1:LINE_W];

  wire accept = req_valid && !waiting;
  wire is_ll  = accept && (req_op == OP_LL);
  wire is_sc  = accept && (req_op == OP_SC);
  wire is_st  = accept && (req_op == OP_ST);

  wire snoop_hit  = snoop_valid && resv_valid && (snoop_tag == resv_tag);
  wire req_hit    = resv_valid && (req_tag == resv_tag);
  wire ll_clash   = snoop_valid && (snoop_tag == req_tag);
  wire sc_go      = is_sc && req_hit && !snoop_hit;
  wire sc_early   = is_sc && !sc_go;
  wire wait_fail  = waiting && snoop_hit;
  wire wait_win   = waiting && !snoop_hit && bus_gnt;
  wire sc_finish  = sc_early || wait_fail || wait_win;

  assign req_ready = !waiting;
  assign bus_req   = waiting;
  assign mem_raddr = req_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (sc_go) begin
      waiting   <= 1'b1;
      pend_addr <= req_addr;
      pend_data <= req_wdata;
    end else if (wait_fail || wait_win) begin
      waiting   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_tag   <= '0;
    end else if (is_ll) begin
      resv_valid <= !ll_clash;
      resv_tag   <= req_tag;
    end else if (sc_finish || snoop_hit || (is_st && req_hit)) begin
      resv_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ll_valid  <= 1'b0;
      ll_data   <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      sc_done   <= 1'b0;
      sc_ok     <= 1'b0;
    end else begin
      ll_valid <= is_ll;
      if (is_ll) ll_data <= mem_rdata;
      mem_we  <= is_st || wait_win;
      if (is_st) begin
        mem_waddr <= req_addr;
        mem_wdata <= req_wdata;
      end else if (wait_win) begin
        mem_waddr <= pend_addr;
        mem_wdata <= pend_data;
      end
      sc_done <= sc_finish;
      sc_ok   <= wait_win;
    end
  end

  a_r1_ll_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == OP_LL) |=> ll_valid);

  a_r2_win_has_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done && sc_ok) |-> ($past(bus_gnt) && mem_we));

  a_r3_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done && !sc_ok) |-> !mem_we);

  a_r3_early_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == OP_SC && !resv_valid) |=> (!bus_req && sc_done && !sc_ok));

  a_r5_snoop_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && snoop_valid && snoop_addr[ADDR_W-1:LINE_W] == pend_addr[ADDR_W-1:LINE_W])
    |=> (sc_done && !sc_ok && !bus_req));

  a_r6_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> !resv_valid);

endmodule

// File: tb/sim_resv_monitor.sv
module sim_resv_monitor;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic req_ready;
  logic [AW-1:0] mem_raddr;
  logic [DW-1:0] mem_rdata;
  logic ll_valid;
  logic [DW-1:0] ll_data;
  logic snoop_valid = 0;
  logic [AW-1:0] snoop_addr = 0;
  logic bus_req, bus_gnt = 0;
  logic mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic sc_done, sc_ok;

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [0:(1<<AW)-1];

  always #2 clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .DATA_W(DW), .LINE_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .ll_valid(ll_valid),
    .ll_data(ll_data), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .sc_done(sc_done), .sc_ok(sc_ok));

  assign mem_rdata = mem[mem_raddr];
  always @(posedge clk) if (mem_we) mem[mem_waddr] <= mem_wdata;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                       logic sv = 0, logic [AW-1:0] sa = 0);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    snoop_valid = sv; snoop_addr = sa;
    @(negedge clk);
    req_valid = 0; req_op = 0; snoop_valid = 0;
  endtask

  task automatic snoop(logic [AW-1:0] a);
    @(negedge clk);
    snoop_valid = 1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 0;
  endtask

  task automatic grant(logic sv = 0, logic [AW-1:0] sa = 0);
    @(negedge clk);
    bus_gnt = 1; snoop_valid = sv; snoop_addr = sa;
    @(negedge clk);
    bus_gnt = 0; snoop_valid = 0;
  endtask

  task automatic sc_expect_fail(string tag, logic [AW-1:0] a);
    issue(2'b10, a, 32'hDEAD0000);
    chk({tag, " sc_done"}, sc_done, 1);
    chk({tag, " sc_ok"}, sc_ok, 0);
    chk({tag, " bus_req"}, bus_req, 0);
    chk({tag, " mem_we"}, mem_we, 0);
  endtask

  task automatic sc_expect_win(string tag, logic [AW-1:0] a, logic [DW-1:0] d);
    issue(2'b10, a, d);
    chk({tag, " bus_req"}, bus_req, 1);
    chk({tag, " no early done"}, sc_done, 0);
    grant();
    chk({tag, " sc_done"}, sc_done, 1);
    chk({tag, " sc_ok"}, sc_ok, 1);
    chk({tag, " mem_we"}, mem_we, 1);
    chk({tag, " waddr"}, mem_waddr, a);
    chk({tag, " wdata"}, mem_wdata, d);
    chk({tag, " bus_req drop"}, bus_req, 0);
  endtask

  task automatic t_reset;
    chk("R10 ready", req_ready, 1);
    chk("R10 bus_req", bus_req, 0);
    chk("R10 mem_we", mem_we, 0);
    chk("R10 sc_done", sc_done, 0);
    chk("R10 ll_valid", ll_valid, 0);
    sc_expect_fail("R10 no reservation", 10'h010);
  endtask

  task automatic t_ll_sc;
    mem[10'h040] = 32'hA5A51234;
    issue(2'b01, 10'h040, 0);
    chk("R1 ll_valid", ll_valid, 1);
    chk("R1 ll_data", ll_data, 32'hA5A51234);
    issue(2'b10, 10'h041, 32'h11112222);
    chk("R2 bus_req", bus_req, 1);
    chk("R2 ready low", req_ready, 0);
    repeat (3) @(negedge clk);
    chk("R2 bus_req held", bus_req, 1);
    chk("R2 no done while waiting", sc_done, 0);
    grant();
    chk("R2 sc_done", sc_done, 1);
    chk("R2 sc_ok", sc_ok, 1);
    chk("R2 mem_we", mem_we, 1);
    chk("R2 waddr", mem_waddr, 10'h041);
    chk("R2 wdata", mem_wdata, 32'h11112222);
    @(negedge clk);
    chk("R2 mem_we pulse", mem_we, 0);
    chk("R2 memory", mem[10'h041], 32'h11112222);
    sc_expect_fail("R6 second sc", 10'h041);
  endtask

  task automatic t_other_line;
    issue(2'b01, 10'h080, 0);
    sc_expect_fail("R3 other line", 10'h090);
    sc_expect_fail("R6 after fail", 10'h080);
  endtask

  task automatic t_snoop;
    issue(2'b01, 10'h100, 0);
    snoop(10'h103);
    sc_expect_fail("R4 same line snoop", 10'h100);
    issue(2'b01, 10'h100, 0);
    snoop(10'h104);
    sc_expect_win("R4 other line snoop", 10'h102, 32'h0BADF00D);
  endtask

  task automatic t_wait_snoop;
    issue(2'b01, 10'h200, 0);
    issue(2'b10, 10'h200, 32'h77777777);
    chk("R5 bus_req", bus_req, 1);
    grant(1, 10'h201);
    chk("R5 sc_done", sc_done, 1);
    chk("R5 sc_ok", sc_ok, 0);
    chk("R5 mem_we", mem_we, 0);
    chk("R5 bus_req drop", bus_req, 0);
    issue(2'b01, 10'h210, 0);
    issue(2'b10, 10'h210, 32'h1);
    snoop(10'h213);
    chk("R5 snoop before grant", sc_done, 1);
    chk("R5 snoop before grant ok", sc_ok, 0);
    chk("R5 snoop before grant we", mem_we, 0);
  endtask

  task automatic t_replace;
    issue(2'b01, 10'h300, 0);
    issue(2'b01, 10'h340, 0);
    sc_expect_fail("R7 old line", 10'h300);
    issue(2'b01, 10'h300, 0);
    issue(2'b01, 10'h340, 0);
    sc_expect_win("R7 new line", 10'h340, 32'hCAFE0001);
  endtask

  task automatic t_store;
    issue(2'b01, 10'h380, 0);
    issue(2'b11, 10'h381, 32'h55AA55AA);
    chk("R8 mem_we", mem_we, 1);
    chk("R8 waddr", mem_waddr, 10'h381);
    chk("R8 wdata", mem_wdata, 32'h55AA55AA);
    sc_expect_fail("R8 store hit clears", 10'h380);
    issue(2'b01, 10'h3C0, 0);
    issue(2'b11, 10'h010, 32'h3);
    sc_expect_win("R8 store miss keeps", 10'h3C0, 32'hCAFE0002);
  endtask

  task automatic t_ll_clash;
    issue(2'b01, 10'h180, 0, 1, 10'h182);
    sc_expect_fail("R9 ll with snoop", 10'h180);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = i * 32'h01010101;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ll_sc();
    t_other_line();
    t_snoop();
    t_wait_snoop();
    t_replace();
    t_store();
    t_ll_clash();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule